// File: doc/BRIEF.md
# Character LCD Nibble Write Engine

This block sends command and data bytes to a character display that is wired with a 4-bit data bus. A single request carries a byte, a register-select flag and a mode flag, and the block takes it through a valid/ready handshake. In byte mode the block splits the byte into two enable strobes, the high half first. In raw mode it sends only the low four bits as one strobe. A power-on sequencer uses raw mode for its first steps.

The block applies every timing rule of the display bus by counting cycles of a 50 MHz clock. It holds the bus steady for a setup interval before enable rises and holds enable high for a minimum pulse width. It keeps enable low for a minimum gap between the two halves of a byte. After the last strobe it waits a settling interval before it raises ready again. That interval is much longer when the byte is the clear-screen command, which is 0x01 with register-select low. The display is never read, so the read/write line stays low at all times.

Top module: `lcd_nibble_writer`

## Requirements
- R1: After reset, ready_o is 1, lcd_e_o is 0, lcd_data_o is 0x0, lcd_rs_o is 0 and lcd_rw_o is 0.
- R2: A request is taken on a clock edge where valid_i and ready_o are both 1. ready_o goes to 0 on the next cycle and stays 0 until the settling interval ends. A request made while ready_o is 0 is dropped and has no effect on the bus.
- R3: lcd_data_o and lcd_rs_o hold their values for SETUP_CYC cycles (default 2) with lcd_e_o low before each rising edge of lcd_e_o.
- R4: Every enable pulse lasts exactly PULSE_CYC cycles (default 12).
- R5: In byte mode (nibble_i = 0), the first strobe carries byte_i[7:4] and the second carries byte_i[3:0].
- R6: Between the two strobes of one byte, lcd_e_o stays low for GAP_CYC + SETUP_CYC cycles (default 50 + 2). The low nibble is on the bus for that whole time.
- R7: After the last strobe of a byte or raw request, ready_o stays 0 for SETTLE_CYC cycles (default 2000) before it returns to 1.
- R8: When a byte-mode request has byte_i = 0x01 and rs_i = 0, the settling interval is CLEAR_CYC cycles (default 82000). A value of 0x01 with rs_i = 1 gets the normal interval.
- R9: In raw mode (nibble_i = 1), byte_i[3:0] is sent as a single strobe and no second strobe follows.
- R10: lcd_rw_o is 0 in every cycle.
- R11: lcd_rs_o carries the rs_i of the accepted request for the whole transfer. lcd_data_o and lcd_rs_o do not change while lcd_e_o is high. The bus keeps its last values while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 50 MHz nominal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A request is present |
| ready_o | output | 1 | The block can take a request |
| byte_i | input | 8 | Byte to send; only bits 3:0 are used in raw mode |
| rs_i | input | 1 | Register select: 0 for a command, 1 for data |
| nibble_i | input | 1 | 1 selects raw single-nibble mode |
| lcd_data_o | output | 4 | Display data bus |
| lcd_e_o | output | 1 | Display enable strobe |
| lcd_rs_o | output | 1 | Display register select |
| lcd_rw_o | output | 1 | Display read/write, held low |

## Verification
Two events can fall in the same cycle: the end of the settling interval and the arrival of the next request. The bench keeps valid_i high across the end of each transfer while it changes the payload. The follow-up byte is then taken on the first edge where ready_o is 1. A behavioural queue model checks that the new setup phase starts on the very next cycle, with no idle cycle and no lost request. The bench also pulses valid_i with unrelated payloads while the block is busy. The per-cycle comparison of the bus lines then shows that these requests are dropped.

// File: rtl/lcd_nibble_pkg.sv
package lcd_nibble_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_GAP,
    PH_SETTLE
  } phase_e;

  localparam logic [7:0] CLEAR_CODE = 8'h01;
endpackage

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/lcd_req_latch.sv
module lcd_req_latch
  import lcd_nibble_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       capture_i,
  input  logic [7:0] byte_i,
  input  logic       rs_i,
  input  logic       nibble_i,
  input  logic       sel_hi_i,
  output logic [3:0] nib_o,
  output logic       rs_o,
  output logic       is_clear_o
);
  logic [7:0] byte_q;
  logic       rs_q;
  logic       raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      rs_q   <= 1'b0;
      raw_q  <= 1'b0;
    end else if (capture_i) begin
      byte_q <= byte_i;
      rs_q   <= rs_i;
      raw_q  <= nibble_i;
    end
  end

  assign nib_o      = sel_hi_i ? byte_q[7:4] : byte_q[3:0];
  assign rs_o       = rs_q;
  assign is_clear_o = !raw_q && !rs_q && (byte_q == CLEAR_CODE);
endmodule

// File: rtl/lcd_nibble_writer.sv
module lcd_nibble_writer
  import lcd_nibble_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 12,
  parameter int GAP_CYC    = 50,
  parameter int SETTLE_CYC = 2000,
  parameter int CLEAR_CYC  = 82000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  output logic       ready_o,
  input  logic [7:0] byte_i,
  input  logic       rs_i,
  input  logic       nibble_i,
  output logic [3:0] lcd_data_o,
  output logic       lcd_e_o,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o
);
  localparam int MAX_CYC = (CLEAR_CYC > SETTLE_CYC) ? CLEAR_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_GAP    = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CLEAR  = CNT_W'(CLEAR_CYC - 1);

  phase_e           phase_q, phase_d;
  logic             hi_q, hi_d;
  logic             accept;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;
  logic             is_clear;

  assign accept = valid_i && (phase_q == PH_IDLE);

  lcd_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  lcd_req_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (accept),
    .byte_i     (byte_i),
    .rs_i       (rs_i),
    .nibble_i   (nibble_i),
    .sel_hi_i   (hi_q),
    .nib_o      (lcd_data_o),
    .rs_o       (lcd_rs_o),
    .is_clear_o (is_clear)
  );

  always_comb begin
    phase_d  = phase_q;
    hi_d     = hi_q;
    load     = 1'b0;
    load_val = '0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        phase_d  = PH_SETUP;
        hi_d     = !nibble_i;  // raw mode starts on the low half
        load     = 1'b1;
        load_val = LD_SETUP;
      end
      PH_SETUP: if (expired) begin
        phase_d  = PH_PULSE;
        load     = 1'b1;
        load_val = LD_PULSE;
      end
      PH_PULSE: if (expired) begin
        load = 1'b1;
        if (hi_q) begin
          phase_d  = PH_GAP;
          hi_d     = 1'b0;
          load_val = LD_GAP;
        end else begin
          phase_d  = PH_SETTLE;
          load_val = is_clear ? LD_CLEAR : LD_SETTLE;
        end
      end
      PH_GAP: if (expired) begin
        phase_d  = PH_SETUP;
        load     = 1'b1;
        load_val = LD_SETUP;
      end
      PH_SETTLE: if (expired) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      hi_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      hi_q    <= hi_d;
    end
  end

  assign ready_o  = (phase_q == PH_IDLE);
  assign lcd_e_o  = (phase_q == PH_PULSE);
  assign lcd_rw_o = 1'b0;
endmodule

// File: rtl/lcd_nibble_writer_chk.sv
module lcd_nibble_writer_chk #(
  parameter int PULSE_CYC = 12
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       ready_o,
  input logic [3:0] lcd_data_o,
  input logic       lcd_e_o,
  input logic       lcd_rs_o,
  input logic       lcd_rw_o
);
  int unsigned hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_cnt <= 0;
    else if (lcd_e_o) hi_cnt <= hi_cnt + 1;
    else              hi_cnt <= 0;
  end

  p_rw_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_rw_o == 1'b0);

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !ready_o);

  p_idle_no_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !lcd_e_o);

  p_setup_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_e_o) |-> $stable(lcd_data_o) && $stable(lcd_rs_o));

  p_pulse_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_e_o) |-> hi_cnt == PULSE_CYC);

  p_bus_steady_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_e_o && $past(lcd_e_o) |-> $stable(lcd_data_o) && $stable(lcd_rs_o));
endmodule

bind lcd_nibble_writer lcd_nibble_writer_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .ready_o    (ready_o),
  .lcd_data_o (lcd_data_o),
  .lcd_e_o    (lcd_e_o),
  .lcd_rs_o   (lcd_rs_o),
  .lcd_rw_o   (lcd_rw_o)
);

// File: tb/tb_lcd_nibble_writer.sv
`timescale 1ns/1ps
module tb_lcd_nibble_writer;
  localparam int SETUP  = 2;
  localparam int PULSE  = 12;
  localparam int GAP    = 50;
  localparam int SETTLE = 40;
  localparam int CLEAR  = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] byte_v = '0;
  logic       rs = 1'b0;
  logic       raw = 1'b0;
  logic       ready;
  logic [3:0] data;
  logic       e, lrs, rw;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  lcd_nibble_writer #(
    .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .GAP_CYC(GAP),
    .SETTLE_CYC(SETTLE), .CLEAR_CYC(CLEAR)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .byte_i(byte_v), .rs_i(rs), .nibble_i(raw),
    .lcd_data_o(data), .lcd_e_o(e), .lcd_rs_o(lrs), .lcd_rw_o(rw)
  );

  typedef struct {
    bit       e;
    bit [3:0] d;
    bit       rdy;
    string    tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  bit   exp_rs;

  task automatic add(int n, bit ee, bit [3:0] dd, string tag);
    for (int i = 0; i < n; i++) q.push_back('{ee, dd, 1'b0, tag});
  endtask

  // reference model, updated on each edge from pre-edge inputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      cur    = '{1'b0, 4'h0, 1'b1, "R1"};
      exp_rs = 1'b0;
    end else begin
      if (cur.rdy && valid) begin
        exp_rs = rs;
        if (raw) begin
          add(SETUP, 0, byte_v[3:0], "R9");
          add(PULSE, 1, byte_v[3:0], "R9");
          add(SETTLE, 0, byte_v[3:0], "R7");
        end else begin
          add(SETUP, 0, byte_v[7:4], "R3");
          add(PULSE, 1, byte_v[7:4], "R5");
          add(GAP + SETUP, 0, byte_v[3:0], "R6");
          add(PULSE, 1, byte_v[3:0], "R4");
          if (!rs && byte_v == 8'h01) add(CLEAR, 0, byte_v[3:0], "R8");
          else                        add(SETTLE, 0, byte_v[3:0], "R7");
        end
      end
      if (q.size() > 0) cur = q.pop_front();
      else              cur = '{1'b0, cur.d, 1'b1, "R2"};
    end
  end

  // R11: per-cycle compare also covers bus stability and idle hold
  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if (e !== cur.e || data !== cur.d || ready !== cur.rdy ||
          lrs !== exp_rs || rw !== 1'b0) begin
        n_fail++;
        $display("FAIL %s/R10/R11 t=%0t got e=%b d=%h rdy=%b rs=%b rw=%b exp e=%b d=%h rdy=%b rs=%b rw=0",
                 cur.tag, $time, e, data, ready, lrs, rw, cur.e, cur.d, cur.rdy, exp_rs);
      end
    end
  end

  task automatic send(bit [7:0] b, bit r, bit n);
    byte_v = b; rs = r; raw = n; valid = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drop_valid();
    valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;  // R1 during reset
    if (ready !== 1'b1 || e !== 1'b0 || data !== 4'h0 || lrs !== 1'b0 || rw !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 got rdy=%b e=%b d=%h rs=%b rw=%b exp 1 0 0 0 0", ready, e, data, lrs, rw);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(8'hA5, 1'b1, 1'b0); drop_valid(); wait_idle();   // R5 data byte
    send(8'h01, 1'b0, 1'b0); drop_valid(); wait_idle();   // R8 clear
    send(8'h01, 1'b1, 1'b0); drop_valid(); wait_idle();   // R8 not clear
    send(8'h3C, 1'b0, 1'b1); drop_valid(); wait_idle();   // R9 raw

    // R2: requests while busy are dropped
    send(8'h5A, 1'b1, 1'b0); drop_valid();
    for (int i = 0; i < 20; i++) begin
      byte_v = 8'(i * 37); rs = i[0]; raw = i[1]; valid = i[2];
      @(negedge clk);
    end
    drop_valid(); wait_idle();

    // back-to-back: valid held high across end of settle
    send(8'h28, 1'b0, 1'b0);
    send(8'h06, 1'b0, 1'b0);
    send(8'h0C, 1'b0, 1'b0);
    send(8'h32, 1'b0, 1'b1);
    send(8'h01, 1'b0, 1'b0);
    drop_valid(); wait_idle();
    repeat (10) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule